// File: doc/BRIEF.md
# Ticket Lock Unit

A hardware mutual-exclusion lock shared by several requesters that grants ownership strictly in the order the requests arrived. Two wrapping counters do the work. One counts tickets handed out. The other counts releases completed. When a requester asks for the lock, it receives the current value of the ticket counter as its ticket, and that counter advances by one in the same step. The requester then waits until the release counter reaches its ticket.

While a requester waits it only compares its stored ticket against the release counter. It causes no further counter updates. The holder gives the lock up with a release, which advances the release counter and so passes ownership to the next ticket. When several requesters ask in the same cycle, a fixed-priority front end serialises them. Each one receives a distinct ticket inside that single cycle.

Each requester drives an acquire pulse and a release pulse and sees a level grant. A sticky error flag records any release issued by a requester that does not own the lock.

Top module: `ticket_lock_unit`

## Requirements
- R1: After reset no grant is high, the error flag is low and both counters are zero, so the first accepted acquire is served first.
- R2: An acquire from an idle requester sampled at clock edge k, when no other ticket is outstanding, raises that requester's grant after edge k+1 and not before.
- R3: Acquires sampled at the same edge are given consecutive tickets in ascending requester index (bit 0 first), so the lower index is granted first.
- R4: Grant is a level: it stays high on every cycle until the holder's release is sampled, and it is low after that edge.
- R5: A release by the holder, sampled at edge k, advances the release counter by one. The next waiting ticket's grant rises after edge k+1, so there is exactly one cycle with no grant between owners.
- R6: A release from a requester whose grant is low changes no grant and no counter, and it sets the error flag, which stays high until reset.
- R7: An acquire from a requester that is already waiting or holding is ignored and gives it no second ticket.
- R8: At most one grant is high in any cycle.
- R9: Counters are CNT_W bits wide and wrap. First-come order holds across the wrap, and no more than NUM_REQ tickets are ever outstanding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| acq_i | input | NUM_REQ | Per-requester acquire request, one bit per requester |
| rel_i | input | NUM_REQ | Per-requester release request |
| grant_o | output | NUM_REQ | Per-requester ownership level |
| err_o | output | 1 | Sticky flag: a release came from a non-holder |

## Verification
The assertions rely on CNT_W being wide enough that 2^CNT_W exceeds NUM_REQ. Under that condition the distance between the two counters never aliases, and the outstanding-ticket bound and the equality match remain meaningful after a wrap.

The assertions place no rule on the inputs. Releases from non-holders and repeated acquires are legal, and the block handles them. The stimulus therefore mixes directed sequences with pseudo-random acquire and release patterns, and these patterns deliberately include illegal releases. A behavioural queue model follows the same inputs every cycle.

// File: rtl/tlk_pkg.sv
package tlk_pkg;
  localparam int unsigned MAX_PORTS = 32;

  // number of set bits strictly below position idx
  function automatic int unsigned ones_below(input logic [MAX_PORTS-1:0] mask,
                                             input int unsigned idx);
    int unsigned n;
    n = 0;
    for (int unsigned b = 0; b < MAX_PORTS; b++)
      if (b < idx && mask[b]) n++;
    return n;
  endfunction

  // total number of set bits
  function automatic int unsigned ones_total(input logic [MAX_PORTS-1:0] mask);
    return ones_below(mask, MAX_PORTS);
  endfunction
endpackage

// File: rtl/tlk_dispenser.sv
module tlk_dispenser #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_REQ-1:0]            take_i,
  output logic [NUM_REQ-1:0][CNT_W-1:0] tkt_o,
  output logic [CNT_W-1:0]              next_o
);
  import tlk_pkg::*;

  logic [CNT_W-1:0]     next_q;
  logic [MAX_PORTS-1:0] take_ext;
  logic [CNT_W-1:0]     taken_n;

  assign take_ext = MAX_PORTS'(take_i);
  assign taken_n  = CNT_W'(ones_total(take_ext));

  // fixed priority: lower index draws the earlier ticket
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_tkt
    assign tkt_o[i] = next_q + CNT_W'(ones_below(take_ext, i));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) next_q <= '0;
    else        next_q <= next_q + taken_n;
  end

  assign next_o = next_q;

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i == '0) |=> (next_q == $past(next_q)));
endmodule

// File: rtl/tlk_slot.sv
module tlk_slot #(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_i,
  input  logic [CNT_W-1:0] tkt_i,
  input  logic [CNT_W-1:0] serve_i,
  input  logic             rel_ok_i,
  output logic             busy_o,
  output logic             match_o,
  output logic             grant_o
);
  logic             busy_q;
  logic             grant_q;
  logic [CNT_W-1:0] tkt_q;

  assign match_o = busy_q && !grant_q && (tkt_q == serve_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      grant_q <= 1'b0;
      tkt_q   <= '0;
    end else begin
      if (take_i) begin
        busy_q <= 1'b1;
        tkt_q  <= tkt_i;
      end else if (rel_ok_i) begin
        busy_q <= 1'b0;
      end
      if (rel_ok_i)     grant_q <= 1'b0;
      else if (match_o) grant_q <= 1'b1;
    end
  end

  assign busy_o  = busy_q;
  assign grant_o = grant_q;

  // R2
  grant_ticket_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_q |-> (busy_q && tkt_q == serve_i));
  // R4
  grant_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ok_i |=> !grant_q);
  // R4
  grant_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_q && !rel_ok_i) |=> grant_q);
  // R7
  no_retake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> !take_i);
endmodule

// File: rtl/tlk_release.sv
module tlk_release #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] rel_i,
  input  logic [NUM_REQ-1:0] grant_i,
  output logic [NUM_REQ-1:0] rel_ok_o,
  output logic [CNT_W-1:0]   serve_o,
  output logic               err_o
);
  logic [CNT_W-1:0] serve_q;
  logic             err_q;
  logic             stray;

  assign rel_ok_o = rel_i & grant_i;
  assign stray    = |(rel_i & ~grant_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      serve_q <= '0;
      err_q   <= 1'b0;
    end else begin
      if (|rel_ok_o) serve_q <= serve_q + 1'b1;
      if (stray)     err_q   <= 1'b1;
    end
  end

  assign serve_o = serve_q;
  assign err_o   = err_q;

  // R5
  serve_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_ok_o) |=> (serve_q == CNT_W'($past(serve_q) + 1)));
  // R6
  serve_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ok_o == '0) |=> $stable(serve_q));
  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |=> err_q);
endmodule

// File: rtl/ticket_lock_unit.sv
module ticket_lock_unit #(
  parameter int unsigned NUM_REQ = 4,
  parameter int unsigned CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_REQ-1:0] acq_i,
  input  logic [NUM_REQ-1:0] rel_i,
  output logic [NUM_REQ-1:0] grant_o,
  output logic               err_o
);
  localparam int unsigned SPAN = 1 << CNT_W;

  logic [NUM_REQ-1:0]            busy;
  logic [NUM_REQ-1:0]            take;
  logic [NUM_REQ-1:0]            match;
  logic [NUM_REQ-1:0]            grant;
  logic [NUM_REQ-1:0]            rel_ok;
  logic [NUM_REQ-1:0][CNT_W-1:0] tkt;
  logic [CNT_W-1:0]              next_tkt;
  logic [CNT_W-1:0]              serve;
  logic [CNT_W-1:0]              outstanding;

  assign take        = acq_i & ~busy;
  assign outstanding = next_tkt - serve;

  tlk_dispenser #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_disp (
    .clk    (clk),
    .rst_n  (rst_n),
    .take_i (take),
    .tkt_o  (tkt),
    .next_o (next_tkt)
  );

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_slot
    tlk_slot #(.CNT_W(CNT_W)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .take_i   (take[i]),
      .tkt_i    (tkt[i]),
      .serve_i  (serve),
      .rel_ok_i (rel_ok[i]),
      .busy_o   (busy[i]),
      .match_o  (match[i]),
      .grant_o  (grant[i])
    );
  end

  tlk_release #(.NUM_REQ(NUM_REQ), .CNT_W(CNT_W)) u_rel (
    .clk      (clk),
    .rst_n    (rst_n),
    .rel_i    (rel_i),
    .grant_i  (grant),
    .rel_ok_o (rel_ok),
    .serve_o  (serve),
    .err_o    (err_o)
  );

  assign grant_o = grant;

  // R9
  wrap_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    SPAN > NUM_REQ);
  // R8
  one_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  // R8
  one_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(match));
  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(outstanding) <= NUM_REQ);
  // R5
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|rel_ok) |=> (grant == '0));
endmodule

// File: tb/ticket_lock_unit_tb.sv
module ticket_lock_unit_tb;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] acq_i = '0;
  logic [N-1:0] rel_i = '0;
  logic [N-1:0] grant_o;
  logic         err_o;

  int checks = 0;
  int errors = 0;

  int     q[$];
  bit [N-1:0] m_grant;
  bit     m_err;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  ticket_lock_unit #(.NUM_REQ(N), .CNT_W(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq_i(acq_i), .rel_i(rel_i),
    .grant_o(grant_o), .err_o(err_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit in_queue(input int r);
    foreach (q[k]) if (q[k] == r) return 1'b1;
    return 1'b0;
  endfunction

  // reference: queue of requester indices in ticket order
  task automatic model_edge(input bit [N-1:0] a, input bit [N-1:0] r);
    bit [N-1:0] g;
    bit [N-1:0] busy_pre;
    g = m_grant;
    for (int j = 0; j < N; j++) busy_pre[j] = in_queue(j);
    if (q.size() > 0 && !m_grant[q[0]]) g[q[0]] = 1'b1;
    for (int j = 0; j < N; j++) begin
      if (r[j]) begin
        if (m_grant[j]) begin
          g[j] = 1'b0;
          void'(q.pop_front());
        end else m_err = 1'b1;
      end
    end
    for (int j = 0; j < N; j++)
      if (a[j] && !busy_pre[j]) q.push_back(j);
    m_grant = g;
  endtask

  task automatic compare();
    chk(grant_o == m_grant, "R4 grant vs model", grant_o, m_grant);
    chk(err_o == m_err, "R6 error flag vs model", err_o, m_err);
    chk($countones(grant_o) <= 1, "R8 single owner", grant_o, 1);
  endtask

  task automatic step(input bit [N-1:0] a, input bit [N-1:0] r);
    acq_i = a;
    rel_i = r;
    @(posedge clk);
    model_edge(a, r);
    @(negedge clk);
    compare();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_grant = '0;
    m_err = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk(grant_o == 4'b0000, "R1 no grant after reset", grant_o, 0);
    chk(err_o == 1'b0, "R1 error low after reset", err_o, 0);

    // R2: grant after second edge
    step(4'b0001, 4'b0000);
    chk(grant_o == 4'b0000, "R2 not granted after first edge", grant_o, 0);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b0001, "R2 granted after second edge", grant_o, 1);
    // R4 level hold, R7 repeat acquire ignored
    step(4'b0001, 4'b0000);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b0001, "R4 grant held", grant_o, 1);
    step(4'b0000, 4'b0001);
    chk(grant_o == 4'b0000, "R4 grant dropped on release", grant_o, 0);
    step(4'b0000, 4'b0000);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b0000, "R7 no second ticket for repeat acquire", grant_o, 0);

    // R3: simultaneous acquires by 1,2,3
    step(4'b1110, 4'b0000);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b0010, "R3 lowest index first", grant_o, 2);
    step(4'b0000, 4'b0010);
    chk(grant_o == 4'b0000, "R5 one idle cycle between owners", grant_o, 0);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b0100, "R5 next ticket granted", grant_o, 4);
    // R6 stray release
    step(4'b0000, 4'b1000);
    chk(err_o == 1'b1, "R6 stray release flagged", err_o, 1);
    chk(grant_o == 4'b0100, "R6 stray release ignored", grant_o, 4);
    step(4'b0000, 4'b0100);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b1000, "R3 third ticket served", grant_o, 8);
    step(4'b0000, 4'b1000);
    step(4'b0000, 4'b0000);

    // R9: many rounds so counters wrap several times
    for (int k = 0; k < 20; k++) begin
      step(4'b1111, 4'b0000);
      for (int s = 0; s < N; s++) begin
        step(4'b0000, 4'b0000);
        chk(grant_o == 4'(1 << s), "R9 order across wrap", grant_o, 1 << s);
        step(4'b0000, 4'(1 << s));
      end
    end

    // pseudo-random mix
    for (int k = 0; k < 1500; k++) begin
      bit [N-1:0] a;
      bit [N-1:0] r;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      a = lfsr[3:0] & lfsr[7:4];
      r = (lfsr[9:8] == 2'b00) ? m_grant : ((lfsr[11:10] == 2'b11) ? lfsr[15:12] : 4'b0000);
      step(a, r);
    end

    // R1 reset again clears flag
    rst_n = 1'b0;
    acq_i = '0;
    rel_i = '0;
    @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q.delete();
    m_grant = '0;
    m_err = 1'b0;
    chk(err_o == 1'b0 && grant_o == 4'b0000, "R1 reset clears state", {err_o, grant_o}, 0);
    step(4'b0100, 4'b0000);
    step(4'b0000, 4'b0000);
    chk(grant_o == 4'b0100, "R1 counters restart", grant_o, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule